// File: doc/BRIEF.md
# Load/Store Alignment Exception Checker

This block sits ahead of the data cache port of a load/store unit. It decides whether a data access must be stopped with an alignment exception before the access starts. Each request carries an effective address, an operand size, an instruction class, the translation controls (data relocation enable, segment direct-store flag, block-translation hit) and the write-through and cache-inhibit attributes of the target. One cycle after a request is presented the block reports a verdict. It either raises a fault flag, which also loads the fault address register, or it raises a go signal that permits the access. It never raises both.

A size-based fault is raised only when a misaligned operand would run past the end of a 4-KB page under page translation. Misaligned operands that stay inside a page are not flagged, because the memory side splits those. The cache-block-zero class faults on its target attributes alone. For a reservation access whose address is not word-aligned, the captured fault address is the effective address plus 4.

The request side has a valid strobe and no ready. The block accepts a request on every cycle, so it never applies back-pressure. A consumer must take each verdict in the cycle in which `done` is high.

Top module: `align_fault_check`

## Requirements
- R1: An access counts as page-translated only when `reloc_en`=1, `direct_store`=0 and `blk_hit`=0. When it is not page-translated, no size-based fault is raised.
- R2: A byte operand (`in_size`=0) never raises a size-based fault.
- R3: A half-word operand (`in_size`=1) in a page-translated access faults exactly when `in_ea[11:0]` is 0xFFF.
- R4: A word operand (`in_size`=2) in a page-translated access faults exactly when `in_ea[11:0]` is 0xFFD, 0xFFE or 0xFFF.
- R5: A double-word operand (`in_size`=3) in a page-translated access faults exactly when `in_ea[11:0]` is in 0xFF9..0xFFF.
- R6: The string/multiple class (`in_class`=1) never faults, whatever its size, address or translation inputs.
- R7: The cache-block-zero class (`in_class`=3) faults exactly when `attr_wt` or `attr_ci` is 1. The address, the size and the translation inputs have no effect on it. In the other classes (ordinary=0, reservation=2) the page-crossing rule of R1..R5 applies.
- R8: On a fault in the ordinary or cache-block-zero class, `fault_ea` becomes `in_ea`.
- R9: On a fault in the reservation class, `fault_ea` becomes `in_ea`+4 (modulo 2^32) when `in_ea[1:0]`≠0, and `in_ea` otherwise.
- R10: `done`, `fault` and `access_go` appear on the clock edge that samples `in_valid`=1 and last one cycle. Without `in_valid`, `done` stays low.
- R11: `access_go` = `done` and not `fault`, so a faulting request never receives a go.
- R12: A synchronous reset clears `done`, `fault` and `access_go`, even while `in_valid` is high.
- R13: `fault_ea` keeps its value across requests that do not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_ea | input | 32 | Effective address |
| in_size | input | 2 | Operand size: 0 byte, 1 half, 2 word, 3 double |
| in_class | input | 2 | 0 ordinary, 1 string/multiple, 2 reservation, 3 cache-block-zero |
| reloc_en | input | 1 | Data relocation enabled |
| direct_store | input | 1 | Segment is a direct-store segment |
| blk_hit | input | 1 | Block-translation entry matched |
| attr_wt | input | 1 | Target is write-through |
| attr_ci | input | 1 | Target is cache-inhibited |
| done | output | 1 | One-cycle verdict pulse |
| fault | output | 1 | Alignment exception for this request |
| access_go | output | 1 | Access may proceed |
| fault_ea | output | 32 | Fault address register |

## Verification
Every result of this block is due exactly one clock edge after the request. The bench drives a request on a falling edge and lets one rising edge pass. On the next falling edge it compares `done`, `fault`, `access_go` and, when a fault is expected, `fault_ea`. Between requests it leaves one idle cycle, in which it checks that `done` has dropped and that `fault_ea` has held. The sweep covers every size, class, translation combination and attribute combination at 32 page offsets on both sides of a page boundary.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DBL = 2'd3} afc_size_e;
  typedef enum logic [1:0] {CL_ORD = 2'd0, CL_STRM = 2'd1, CL_RSV = 2'd2, CL_CBZ = 2'd3} afc_class_e;
  localparam int unsigned N_SIZES = 4;
endpackage

// File: rtl/afc_xlate_sel.sv
module afc_xlate_sel (
  input  logic reloc_en,
  input  logic direct_store,
  input  logic blk_hit,
  output logic page_xlate
);
  // Page-table translation only when relocating, not direct-store, no block match
  assign page_xlate = reloc_en & ~direct_store & ~blk_hit;
endmodule

// File: rtl/afc_cross_det.sv
module afc_cross_det
  import afc_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [PAGE_BITS-1:0] offset,
  input  afc_size_e            size,
  output logic                 crosses
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_BITS;
  logic [N_SIZES-1:0] lane_hit;

  // One comparator per operand size: offset + bytes > page size
  for (genvar k = 0; k < N_SIZES; k++) begin : g_lane
    localparam int unsigned LAST_OK = PAGE_BYTES - (1 << k);
    localparam logic [PAGE_BITS:0] THR = LAST_OK[PAGE_BITS:0];
    assign lane_hit[k] = {1'b0, offset} > THR;
  end

  assign crosses = lane_hit[size];
endmodule

// File: rtl/afc_addr_adj.sv
module afc_addr_adj
  import afc_pkg::*;
#(
  parameter int EA_W = 32
) (
  input  logic [EA_W-1:0] ea,
  input  afc_class_e      cls,
  output logic [EA_W-1:0] fault_addr
);
  localparam logic [EA_W-1:0] WORD_STEP = EA_W'(4);
  logic multiword;
  logic unaligned;

  assign multiword  = (cls == CL_RSV) || (cls == CL_STRM);
  assign unaligned  = |ea[1:0];
  assign fault_addr = (multiword && unaligned) ? ea + WORD_STEP : ea;
endmodule

// File: rtl/align_fault_check.sv
module align_fault_check
  import afc_pkg::*;
#(
  parameter int EA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [EA_W-1:0] in_ea,
  input  logic [1:0]      in_size,
  input  logic [1:0]      in_class,
  input  logic            reloc_en,
  input  logic            direct_store,
  input  logic            blk_hit,
  input  logic            attr_wt,
  input  logic            attr_ci,
  output logic            done,
  output logic            fault,
  output logic            access_go,
  output logic [EA_W-1:0] fault_ea
);
  afc_size_e  size_q;
  afc_class_e cls_q;
  logic       page_xlate;
  logic       crosses;
  logic       fault_nxt;
  logic [EA_W-1:0] adj_ea;

  assign size_q = afc_size_e'(in_size);
  assign cls_q  = afc_class_e'(in_class);

  afc_xlate_sel u_xlate (
    .reloc_en     (reloc_en),
    .direct_store (direct_store),
    .blk_hit      (blk_hit),
    .page_xlate   (page_xlate)
  );

  afc_cross_det #(.PAGE_BITS(PAGE_BITS)) u_cross (
    .offset  (in_ea[PAGE_BITS-1:0]),
    .size    (size_q),
    .crosses (crosses)
  );

  afc_addr_adj #(.EA_W(EA_W)) u_adj (
    .ea         (in_ea),
    .cls        (cls_q),
    .fault_addr (adj_ea)
  );

  always_comb begin
    unique case (cls_q)
      CL_CBZ:  fault_nxt = attr_wt | attr_ci;
      CL_STRM: fault_nxt = 1'b0;
      default: fault_nxt = page_xlate & crosses;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      fault     <= 1'b0;
      access_go <= 1'b0;
    end else begin
      done      <= in_valid;
      fault     <= in_valid & fault_nxt;
      access_go <= in_valid & ~fault_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && in_valid && fault_nxt) fault_ea <= adj_ea;
  end
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int EA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [EA_W-1:0] in_ea,
  input logic [1:0]      in_size,
  input logic [1:0]      in_class,
  input logic            done,
  input logic            fault,
  input logic            access_go
);
  AST_FAULT_NO_GO: assert property (@(posedge clk) disable iff (rst) !(fault && access_go)); // R11
  AST_VERDICT_HAS_DONE: assert property (@(posedge clk) disable iff (rst) (fault || access_go) |-> done); // R11
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> done); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !done); // R10
  AST_BYTE_SAFE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == 2'd0 && in_class != 2'd3) |=> !fault); // R2
  AST_STRM_SAFE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 2'd1) |=> !fault); // R6
  AST_INNER_SAFE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class != 2'd3 && in_ea[11:3] != 9'h1FF) |=> !fault); // R5
endmodule

bind align_fault_check afc_checker #(.EA_W(EA_W)) u_afc_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ea     (in_ea),
  .in_size   (in_size),
  .in_class  (in_class),
  .done      (done),
  .fault     (fault),
  .access_go (access_go)
);

// File: tb/align_fault_check_bench.sv
module align_fault_check_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_ea = '0;
  logic [1:0]  in_size = '0;
  logic [1:0]  in_class = '0;
  logic        reloc_en = 1'b0, direct_store = 1'b0, blk_hit = 1'b0;
  logic        attr_wt = 1'b0, attr_ci = 1'b0;
  logic        done, fault, access_go;
  logic [31:0] fault_ea;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_fault_ea = '0;
  logic        have_fault = 1'b0;

  always #4 clk = ~clk;

  align_fault_check u_align_fault_check (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ea(in_ea),
    .in_size(in_size), .in_class(in_class), .reloc_en(reloc_en),
    .direct_store(direct_store), .blk_hit(blk_hit), .attr_wt(attr_wt),
    .attr_ci(attr_ci), .done(done), .fault(fault), .access_go(access_go),
    .fault_ea(fault_ea)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_for(input int sz, input int cl, input bit pt);
    if (cl == 3) return "R7";
    if (cl == 1) return "R6";
    if (!pt) return "R1";
    case (sz)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [31:0] ea, input int sz, input int cl, input int tr, input int at);
    bit pt, exp_fault;
    int nb;
    logic [31:0] exp_ea;
    string tg;
    @(negedge clk);
    in_valid = 1'b1; in_ea = ea; in_size = 2'(sz); in_class = 2'(cl);
    reloc_en = tr[2]; direct_store = tr[1]; blk_hit = tr[0];
    attr_wt = at[1]; attr_ci = at[0];
    pt = tr[2] && !tr[1] && !tr[0];
    nb = 1 << sz;
    if (cl == 3) exp_fault = (at != 0);
    else if (cl == 1) exp_fault = 1'b0;
    else exp_fault = pt && ((int'(ea[11:0]) + nb) > 4096);
    exp_ea = (cl == 2 && ea[1:0] != 2'b00) ? ea + 32'd4 : ea;
    tg = tag_for(sz, cl, pt);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "done", {31'b0, done}, 32'd1);
    chk(tg, "fault", {31'b0, fault}, {31'b0, exp_fault});
    chk("R11", "access_go", {31'b0, access_go}, {31'b0, !exp_fault});
    if (exp_fault) begin
      chk(cl == 2 ? "R9" : "R8", "fault_ea", fault_ea, exp_ea);
      last_fault_ea = exp_ea;
      have_fault = 1'b1;
    end
    @(negedge clk);
    chk("R10", "done idle", {31'b0, done}, 32'd0);
    if (have_fault) chk("R13", "fault_ea hold", fault_ea, last_fault_ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "done in reset", {31'b0, done}, 32'd0);
    chk("R12", "fault in reset", {31'b0, fault}, 32'd0);
    chk("R12", "go in reset", {31'b0, access_go}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "done idle after reset", {31'b0, done}, 32'd0);

    for (int sz = 0; sz < 4; sz++)
      for (int cl = 0; cl < 4; cl++)
        for (int tr = 0; tr < 8; tr++)
          for (int at = 0; at < 4; at++)
            for (int oi = 0; oi < 32; oi++) begin
              logic [31:0] ea;
              ea = (oi < 16) ? (32'h1234_5FF0 + 32'(oi)) : (32'hABCD_E000 + 32'(oi - 16));
              if (oi == 31) ea = 32'hFFFF_FFFF;
              run_op(ea, sz, cl, tr, at);
            end

    // fault then reset while valid: verdict flags cleared
    run_op(32'h0000_0FFF, 3, 0, 4, 0);
    @(negedge clk);
    in_valid = 1'b1; in_ea = 32'h0000_0FFF; in_size = 2'd3; in_class = 2'd0;
    reloc_en = 1'b1; direct_store = 1'b0; blk_hit = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R12", "fault after mid reset", {31'b0, fault}, 32'd0);
    chk("R12", "done after mid reset", {31'b0, done}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule